// File: doc/BRIEF.md
# DMA Ring Descriptor Composer and Slot Indexer

This block turns a buffer request into one 64-bit ring descriptor and stores it in a descriptor RAM at the requested slot. A request carries the buffer's physical address, its size in bytes, the slot number, and three per-request flags: first piece of a frame, last piece of a frame, and raise-interrupt-on-completion.

Three static settings shape each descriptor: the ring length in slots, a frame offset that is subtracted from the buffer size, and a bus translation value. The top two address bits are moved out of the address word into an extension field of the control word. The translation value is OR'd into what remains of the address. The descriptor in the last slot of the ring is marked as the end of the table without any request flag asking for it.

Two combinational converters sit beside the RAM. One turns a slot number into the byte offset that the engine's index register expects. The other turns the engine's byte-offset status pointer back into a slot number. Bus mastering, data movement and buffer allocation belong to other blocks.

Top module: `dma_desc_composer`

## Requirements
- R1: Control word bits 12:0 hold (buffer size minus frame offset) modulo 8192.
- R2: Control bit 28 (end of table) is 1 exactly when the slot equals the configured ring length minus one.
- R3: Control bit 31 carries the frame-start flag, bit 30 the frame-end flag and bit 29 the interrupt flag. The bits not named in R1 to R4 are 0.
- R4: Buffer address bits 31:30 appear in control bits 17:16. The address word is the buffer address with bits 31:30 cleared, OR'd with the translation value.
- R5: An accepted request writes the descriptor at the clock edge. The read port is registered: one edge after `rd_slot_i` is applied, `rd_data_o` holds the address word in bits 63:32 and the control word in bits 31:0. This is the little-endian byte image of the descriptor, control word first.
- R6: `idx_byte_o` equals `idx_slot_i` times 8, combinationally.
- R7: `stat_slot_o` equals the low SLOT_W+3 bits of `stat_ptr_i` divided by 8. Higher pointer bits have no effect.
- R8: A request whose slot is not less than the ring length raises `wr_err_o` for the next cycle, keeps `wr_done_o` low and leaves the RAM unchanged.
- R9: A request whose slot is inside the ring raises `wr_done_o` for the next cycle, with `wr_err_o` low.
- R10: After reset, `wr_err_o`, `wr_done_o` and `rd_data_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_ring_slots_i | input | SLOT_W+1 | Ring length in slots |
| cfg_frame_off_i | input | FOFF_W | Frame offset subtracted from the buffer size |
| cfg_xlat_i | input | 32 | Bus translation value OR'd into the address word |
| wr_valid_i | input | 1 | Request strobe |
| wr_slot_i | input | SLOT_W | Target slot |
| wr_addr_i | input | 32 | Buffer physical address |
| wr_size_i | input | SIZE_W | Buffer size in bytes |
| wr_sof_i | input | 1 | Frame-start flag |
| wr_eof_i | input | 1 | Frame-end flag |
| wr_irq_i | input | 1 | Interrupt-request flag |
| wr_done_o | output | 1 | Previous-cycle request was written |
| wr_err_o | output | 1 | Previous-cycle request was rejected for its slot |
| rd_slot_i | input | SLOT_W | Slot to read back |
| rd_data_o | output | 64 | Registered descriptor image |
| idx_slot_i | input | SLOT_W | Slot to convert into an index byte offset |
| idx_byte_o | output | 32 | Byte offset of `idx_slot_i` |
| stat_ptr_i | input | 32 | Byte-offset pointer read from engine status |
| stat_slot_o | output | SLOT_W | Slot number of `stat_ptr_i` |

## Verification
The assertions assume that the ring configuration is held steady while requests are in flight. They also assume that `wr_valid_i` is driven to a known level from reset onward. The bench changes the configuration only when no request is pending and drives every input from negative clock edges.

The round-trip assertion covers only pointer values that a slot number can produce. The random stimulus reaches the other pointer values by setting the high and low pointer bits at random. Read-back is never issued for a slot that is being written in the same cycle, so the bench does not depend on whether the RAM returns the old or the new data on a collision.

// File: rtl/dmadesc_pkg.sv
package dmadesc_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned DESC_W     = 2 * WORD_W;
  localparam int unsigned DESC_BYTES = DESC_W / 8;
  localparam int unsigned DESC_SHIFT = $clog2(DESC_BYTES);
  localparam int unsigned BCNT_W     = 13;
  localparam int unsigned XLAT_W     = 2;
  localparam int unsigned XLAT_LSB   = WORD_W - XLAT_W;
  localparam logic [WORD_W-1:0] XLAT_MASK = {{XLAT_W{1'b1}}, {XLAT_LSB{1'b0}}};

  typedef struct packed {
    logic              sof;
    logic              eof;
    logic              irq;
    logic              eot;
    logic [9:0]        rsv_hi;
    logic [XLAT_W-1:0] ext;
    logic [2:0]        rsv_lo;
    logic [BCNT_W-1:0] bcnt;
  } desc_ctrl_t;

  typedef struct packed {
    logic [WORD_W-1:0] addr;
    desc_ctrl_t        ctrl;
  } desc_t;
endpackage

// File: rtl/desc_pack.sv
module desc_pack
  import dmadesc_pkg::*;
#(
  parameter int unsigned SLOT_W = 8,
  parameter int unsigned SIZE_W = 16,
  parameter int unsigned FOFF_W = 8
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [SLOT_W:0]   ring_slots_i,
  input  logic [31:0]       addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [FOFF_W-1:0] frame_off_i,
  input  logic [31:0]       xlat_i,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic              irq_i,
  output desc_t             desc_o,
  output logic              slot_ok_o
);
  logic [SLOT_W:0]   slot_ext;
  logic [SIZE_W-1:0] payload;

  assign slot_ext  = {1'b0, slot_i};
  assign slot_ok_o = slot_ext < ring_slots_i;
  assign payload   = size_i - SIZE_W'(frame_off_i);

  always_comb begin
    desc_o             = '0;
    desc_o.ctrl.bcnt   = BCNT_W'(payload);
    desc_o.ctrl.ext    = XLAT_W'((addr_i & XLAT_MASK) >> XLAT_LSB);
    desc_o.ctrl.eot    = (slot_ext == ring_slots_i - 1'b1);
    desc_o.ctrl.sof    = sof_i;
    desc_o.ctrl.eof    = eof_i;
    desc_o.ctrl.irq    = irq_i;
    desc_o.addr        = (addr_i & ~XLAT_MASK) | xlat_i;
  end
endmodule

// File: rtl/desc_ram.sv
module desc_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/slot_ptr_conv.sv
module slot_ptr_conv
  import dmadesc_pkg::*;
#(
  parameter int unsigned SLOT_W = 8
) (
  input  logic [SLOT_W-1:0] slot_i,
  output logic [31:0]       byte_o,
  input  logic [31:0]       ptr_i,
  output logic [SLOT_W-1:0] slot_o
);
  localparam int unsigned PTR_W = SLOT_W + DESC_SHIFT;
  localparam logic [31:0] PTR_MASK = 32'((64'd1 << PTR_W) - 64'd1);

  assign byte_o = 32'(slot_i) << DESC_SHIFT;
  assign slot_o = SLOT_W'((ptr_i & PTR_MASK) >> DESC_SHIFT);
endmodule

// File: rtl/dma_desc_composer.sv
module dma_desc_composer
  import dmadesc_pkg::*;
#(
  parameter int unsigned SLOT_W = 8,
  parameter int unsigned SIZE_W = 16,
  parameter int unsigned FOFF_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SLOT_W:0]   cfg_ring_slots_i,
  input  logic [FOFF_W-1:0] cfg_frame_off_i,
  input  logic [31:0]       cfg_xlat_i,
  input  logic              wr_valid_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [31:0]       wr_addr_i,
  input  logic [SIZE_W-1:0] wr_size_i,
  input  logic              wr_sof_i,
  input  logic              wr_eof_i,
  input  logic              wr_irq_i,
  output logic              wr_done_o,
  output logic              wr_err_o,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output logic [63:0]       rd_data_o,
  input  logic [SLOT_W-1:0] idx_slot_i,
  output logic [31:0]       idx_byte_o,
  input  logic [31:0]       stat_ptr_i,
  output logic [SLOT_W-1:0] stat_slot_o
);
  desc_t desc;
  logic  slot_ok;
  logic  wr_en;

  desc_pack #(.SLOT_W(SLOT_W), .SIZE_W(SIZE_W), .FOFF_W(FOFF_W)) u_pack (
    .slot_i       (wr_slot_i),
    .ring_slots_i (cfg_ring_slots_i),
    .addr_i       (wr_addr_i),
    .size_i       (wr_size_i),
    .frame_off_i  (cfg_frame_off_i),
    .xlat_i       (cfg_xlat_i),
    .sof_i        (wr_sof_i),
    .eof_i        (wr_eof_i),
    .irq_i        (wr_irq_i),
    .desc_o       (desc),
    .slot_ok_o    (slot_ok)
  );

  assign wr_en = wr_valid_i & slot_ok;

  desc_ram #(.AW(SLOT_W), .DW(DESC_W)) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en),
    .waddr_i (wr_slot_i),
    .wdata_i (desc),
    .raddr_i (rd_slot_i),
    .rdata_o (rd_data_o)
  );

  slot_ptr_conv #(.SLOT_W(SLOT_W)) u_conv (
    .slot_i (idx_slot_i),
    .byte_o (idx_byte_o),
    .ptr_i  (stat_ptr_i),
    .slot_o (stat_slot_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_done_o <= 1'b0;
      wr_err_o  <= 1'b0;
    end else begin
      wr_done_o <= wr_en;
      wr_err_o  <= wr_valid_i & ~slot_ok;
    end
  end
endmodule

// File: rtl/dma_desc_composer_chk.sv
module dma_desc_composer_chk #(
  parameter int unsigned SLOT_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SLOT_W:0]   cfg_ring_slots_i,
  input logic              wr_valid_i,
  input logic [SLOT_W-1:0] wr_slot_i,
  input logic              wr_done_o,
  input logic              wr_err_o,
  input logic [SLOT_W-1:0] idx_slot_i,
  input logic [31:0]       idx_byte_o,
  input logic [31:0]       stat_ptr_i,
  input logic [SLOT_W-1:0] stat_slot_o
);
  a_r8_bad_slot_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && ({1'b0, wr_slot_i} >= cfg_ring_slots_i)) |=> (wr_err_o && !wr_done_o));

  a_r9_good_slot_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && ({1'b0, wr_slot_i} < cfg_ring_slots_i)) |=> (wr_done_o && !wr_err_o));

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |=> (!wr_done_o && !wr_err_o));

  a_r6_idx_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_byte_o[2:0] == 3'b000);

  a_r7_round_trip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_ptr_i == idx_byte_o) |-> (stat_slot_o == idx_slot_i));

  a_r10_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!wr_done_o && !wr_err_o));
endmodule

bind dma_desc_composer dma_desc_composer_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .cfg_ring_slots_i (cfg_ring_slots_i),
  .wr_valid_i       (wr_valid_i),
  .wr_slot_i        (wr_slot_i),
  .wr_done_o        (wr_done_o),
  .wr_err_o         (wr_err_o),
  .idx_slot_i       (idx_slot_i),
  .idx_byte_o       (idx_byte_o),
  .stat_ptr_i       (stat_ptr_i),
  .stat_slot_o      (stat_slot_o)
);

// File: tb/tb_dma_desc_composer.sv
module tb_dma_desc_composer;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT_W = 8;
  localparam int SIZE_W = 16;
  localparam int FOFF_W = 8;
  localparam int DEPTH  = 1 << SLOT_W;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [SLOT_W:0]   cfg_ring_slots_i = '0;
  logic [FOFF_W-1:0] cfg_frame_off_i = '0;
  logic [31:0]       cfg_xlat_i = '0;
  logic              wr_valid_i = 1'b0;
  logic [SLOT_W-1:0] wr_slot_i = '0;
  logic [31:0]       wr_addr_i = '0;
  logic [SIZE_W-1:0] wr_size_i = '0;
  logic              wr_sof_i = 1'b0, wr_eof_i = 1'b0, wr_irq_i = 1'b0;
  logic              wr_done_o, wr_err_o;
  logic [SLOT_W-1:0] rd_slot_i = '0;
  logic [63:0]       rd_data_o;
  logic [SLOT_W-1:0] idx_slot_i = '0;
  logic [31:0]       idx_byte_o;
  logic [31:0]       stat_ptr_i = '0;
  logic [SLOT_W-1:0] stat_slot_o;

  int checks = 0;
  int fails  = 0;
  logic [63:0] shadow [DEPTH];
  bit          known  [DEPTH];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dma_desc_composer #(.SLOT_W(SLOT_W), .SIZE_W(SIZE_W), .FOFF_W(FOFF_W)) dut (.*);

  function automatic logic [63:0] model(input logic [SLOT_W-1:0] s, input logic [31:0] a,
                                        input logic [SIZE_W-1:0] sz, input logic sf,
                                        input logic ef, input logic iq);
    logic [SIZE_W-1:0] d;
    logic [31:0] c, w;
    d = sz - SIZE_W'(cfg_frame_off_i);
    c = {sf, ef, iq, ({1'b0, s} == cfg_ring_slots_i - 1'b1), 10'b0, a[31:30], 3'b0, d[12:0]};
    w = {2'b00, a[29:0]} | cfg_xlat_i;
    return {w, c};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [SLOT_W-1:0] s, input logic [31:0] a,
                          input logic [SIZE_W-1:0] sz, input logic sf, input logic ef,
                          input logic iq);
    bit ok;
    @(negedge clk_i);
    wr_valid_i = 1'b1; wr_slot_i = s; wr_addr_i = a; wr_size_i = sz;
    wr_sof_i = sf; wr_eof_i = ef; wr_irq_i = iq;
    ok = ({1'b0, s} < cfg_ring_slots_i);
    if (ok) begin shadow[s] = model(s, a, sz, sf, ef, iq); known[s] = 1'b1; end
    @(posedge clk_i); #1;
    wr_valid_i = 1'b0;
    if (ok) check("R9 done/err", {62'b0, wr_done_o, wr_err_o}, 64'd2);
    else    check("R8 done/err", {62'b0, wr_done_o, wr_err_o}, 64'd1);
  endtask

  task automatic do_read(input logic [SLOT_W-1:0] s, input string req);
    @(negedge clk_i);
    rd_slot_i = s;
    @(posedge clk_i); #1;
    check(req, rd_data_o, shadow[s]);
  endtask

  task automatic do_conv(input logic [SLOT_W-1:0] s, input logic [31:0] p);
    @(negedge clk_i);
    idx_slot_i = s; stat_ptr_i = p;
    #1;
    check("R6 idx byte", {32'b0, idx_byte_o}, {32'b0, 32'(s) * 32'd8});
    check("R7 stat slot", {56'b0, stat_slot_o}, {56'b0, SLOT_W'(p[SLOT_W+2:0] / 8)});
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(posedge clk_i);
    #1;
    check("R10 reset outputs", {wr_done_o, wr_err_o, rd_data_o[61:0]}, 64'd0);
    check("R10 reset data", rd_data_o, 64'd0);
    @(negedge clk_i); rst_ni = 1'b1;

    // directed: ring of 32
    cfg_ring_slots_i = 9'd32; cfg_frame_off_i = 8'd30; cfg_xlat_i = 32'h4000_0000;
    do_write(8'd0, 32'hC123_4568, 16'd2000, 1'b1, 1'b0, 1'b0);   // R1 R3 R4
    do_read(8'd0, "R1/R3/R4/R5 slot0");
    do_write(8'd31, 32'h0000_1000, 16'd10, 1'b0, 1'b1, 1'b1);    // R2 last slot, R1 wrap
    do_read(8'd31, "R2 last slot eot");
    check("R2 eot bit", {63'b0, rd_data_o[28]}, 64'd1);
    check("R1 bytecount wrap", {51'b0, rd_data_o[12:0]}, {51'b0, 13'h1FEC});
    do_write(8'd30, 32'h8000_0010, 16'd64, 1'b0, 1'b0, 1'b0);
    do_read(8'd30, "R2 not last slot");
    check("R4 ext field", {62'b0, rd_data_o[17:16]}, 64'd2);

    // R8: write slot 20 under ring 32, then shrink ring to 16 and retry
    do_write(8'd20, 32'h1234_5678, 16'd100, 1'b1, 1'b1, 1'b0);
    cfg_ring_slots_i = 9'd16;
    do_write(8'd20, 32'hFFFF_FFFF, 16'd7, 1'b0, 1'b0, 1'b1);
    do_read(8'd20, "R8 rejected write leaves slot");
    do_write(8'd15, 32'h0, 16'd30, 1'b0, 1'b0, 1'b0);
    do_read(8'd15, "R2 eot at ring 16");
    do_write(8'd16, 32'h0, 16'd30, 1'b0, 1'b0, 1'b0);

    // R2 at full ring
    cfg_ring_slots_i = 9'd256; cfg_frame_off_i = 8'd0; cfg_xlat_i = 32'h0;
    do_write(8'd255, 32'hFFFF_FFF8, 16'hFFFF, 1'b1, 1'b1, 1'b1);
    do_read(8'd255, "R2 full ring last slot");

    // R6 R7 directed
    do_conv(8'd0, 32'h0);
    do_conv(8'd255, 32'hFFFF_FFFF);
    do_conv(8'd17, 32'h8000_008F);

    // random phase
    cfg_ring_slots_i = 9'd48; cfg_frame_off_i = 8'd12; cfg_xlat_i = 32'h8000_0000;
    for (int i = 0; i < 300; i++) begin
      logic [SLOT_W-1:0] s;
      s = SLOT_W'($urandom_range(0, 63));
      do_write(s, $urandom, SIZE_W'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    for (int s = 0; s < 64; s++) begin
      if (known[s]) do_read(SLOT_W'(s), "R5 random readback");
    end
    for (int i = 0; i < 40; i++) do_conv(SLOT_W'($urandom), $urandom);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule